// File: doc/BRIEF.md
# Burst Refill Buffer Controller

This block keeps a two-half line buffer supplied with image data for a display pipeline. It sits on the memory clock and talks to an external memory that can deliver up to 128 sequential 16-bit words after a single request. Each stored word carries two 8-bit pixels. The display side reads the buffer on its own pixel clock through a registered read port.

After reset the controller loads both halves, one burst each, and then raises `fill_done` so that scanning may start. From then on, the display's reads drive the refills. A read of the last word in the lower half marks that half as spent, and a read of the last word in the upper half marks the upper half. Each marker starts one burst into the spent half. The marker crosses into the memory clock domain as a toggle through a two-flop synchronizer. The controller keeps the frame-wide start address of the next block. That address steps by one block per burst and returns to zero after the final block of the frame. A marker that arrives while a burst is running is held, and it is serviced when that burst ends.

Top module: `burst_refill_ctrl`

## Requirements
- R1: While `mrst_n` is low, `mem_req`, `mem_burst` and `fill_done` are 0 and `mem_addr` is 0.
- R2: After reset, the block issues two bursts without any display activity, at addresses 0 and 128. It writes buffer words 0..127 and then 128..255. `fill_done` goes high once the second burst has finished and then stays high.
- R3: `mem_req` stays high from the start of a request until `mem_begun` is sampled high, and then it drops. Nothing is written until `mem_dvalid` is sampled high. `mem_burst` is high for exactly 128 consecutive cycles, starting in the cycle after that sample.
- R4: Word k (0..127) of a burst into half h is stored at buffer address h*128+k. On the display side, a read with `rd_en` high at `rd_addr` returns that word on `rd_data` after the next `pclk` rising edge.
- R5: A display read at `rd_addr` 127 requests a refill of the lower half. A display read at 255 requests a refill of the upper half. A read at any other address requests nothing.
- R6: Each triggering read produces exactly one burst.
- R7: Each burst starts at the address of the previous burst plus 128.
- R8: After the burst at `FRAME_WORDS`-128, the next burst starts at address 0. `FRAME_WORDS` defaults to 240000 and must be a multiple of 128.
- R9: A trigger that arrives while a burst is running is held and serviced after that burst. Up to two triggers can be held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Memory-side clock |
| mrst_n | input | 1 | Memory-side asynchronous reset, active low |
| mem_req | output | 1 | Burst request to the external memory |
| mem_addr | output | ADDR_W | Start address of the current or next burst |
| mem_begun | input | 1 | Memory has accepted the request |
| mem_dvalid | input | 1 | Data follows from the next cycle |
| mem_data | input | DATA_W | Burst data word |
| mem_burst | output | 1 | Burst transfer active; a word is written each cycle |
| fill_done | output | 1 | Both halves loaded after reset |
| pclk | input | 1 | Pixel clock |
| prst_n | input | 1 | Pixel-side asynchronous reset, active low |
| rd_en | input | 1 | Display read enable |
| rd_addr | input | BUF_AW | Display read address |
| rd_data | output | DATA_W | Display read data, one pixel clock after the read |

## Verification
`rd_data` is due one `pclk` edge after a read. The bench drives reads on the falling edge and samples at the next falling edge. A trigger reaches the memory side after two or three `mclk` edges of synchronizer plus one state step. Because that delay is not fixed, the bench does not count edges for the request. It waits until the memory model has logged a finished burst and then reads the refilled words.

The memory model checks the handshake against its own edges. It expects `mem_req` to be held on the two falling edges before it raises `mem_begun`. It expects `mem_burst` to be low on the edge that carries `mem_dvalid`, high on each of the 128 following edges, and low again on the edge after those.

// File: rtl/burst_refill_ctrl.sv
module burst_refill_ctrl #(
  parameter int DATA_W      = 16,
  parameter int HALF_WORDS  = 128,
  parameter int FRAME_WORDS = 240000,
  parameter int ADDR_W      = $clog2(FRAME_WORDS),
  parameter int BUF_AW      = $clog2(2*HALF_WORDS)
) (
  input  logic              mclk,
  input  logic              mrst_n,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_begun,
  input  logic              mem_dvalid,
  input  logic [DATA_W-1:0] mem_data,
  output logic              mem_burst,
  output logic              fill_done,
  input  logic              pclk,
  input  logic              prst_n,
  input  logic              rd_en,
  input  logic [BUF_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int CNT_W = $clog2(HALF_WORDS);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(HALF_WORDS-1);
  localparam logic [ADDR_W-1:0] LAST_BLK  = ADDR_W'(FRAME_WORDS-HALF_WORDS);
  localparam logic [ADDR_W-1:0] BLK_STEP  = ADDR_W'(HALF_WORDS);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_XFER, S_NEXT} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic             half;
  logic [1:0]       pend;
  logic             p_tgl;
  logic [2:0]       sync;
  logic [DATA_W-1:0] buffer [2*HALF_WORDS];

  wire evt    = sync[2] ^ sync[1];
  wire launch = (st == S_IDLE) && (!fill_done || pend != 2'd0);
  wire take   = launch && fill_done;
  wire mark   = rd_en && (rd_addr == BUF_AW'(HALF_WORDS-1) || rd_addr == BUF_AW'(2*HALF_WORDS-1));

  assign mem_req   = (st == S_REQ);
  assign mem_burst = (st == S_XFER);

  always_ff @(posedge pclk or negedge prst_n)
    if (!prst_n)   p_tgl <= 1'b0;
    else if (mark) p_tgl <= ~p_tgl;

  always_ff @(posedge pclk)
    if (rd_en) rd_data <= buffer[rd_addr];

  always_ff @(posedge mclk)
    if (mem_burst) buffer[{half, cnt}] <= mem_data;

  always_ff @(posedge mclk or negedge mrst_n)
    if (!mrst_n) sync <= 3'b000;
    else         sync <= {sync[1:0], p_tgl};

  always_ff @(posedge mclk or negedge mrst_n)
    if (!mrst_n) pend <= 2'd0;
    else if (evt && !take && pend != 2'd2) pend <= pend + 2'd1;
    else if (!evt && take)                 pend <= pend - 2'd1;

  always_ff @(posedge mclk or negedge mrst_n) begin
    if (!mrst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      half      <= 1'b0;
      fill_done <= 1'b0;
      mem_addr  <= '0;
    end else begin
      case (st)
        S_IDLE: if (launch) st <= S_REQ;
        S_REQ:  if (mem_begun) st <= S_WAIT;
        S_WAIT: if (mem_dvalid) begin
          st  <= S_XFER;
          cnt <= '0;
        end
        S_XFER: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_LAST) st <= S_NEXT;
        end
        S_NEXT: begin
          half <= ~half;
          if (half) fill_done <= 1'b1;
          mem_addr <= (mem_addr >= LAST_BLK) ? '0 : mem_addr + BLK_STEP;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge mclk) disable iff (!mrst_n)
    (mem_req && !mem_begun) |=> mem_req);

  // R3
  burst_start_chk: assert property (@(posedge mclk) disable iff (!mrst_n)
    (st == S_WAIT && mem_dvalid) |=> mem_burst);

  // R3
  burst_len_chk: assert property (@(posedge mclk) disable iff (!mrst_n)
    $fell(mem_burst) |-> $past(cnt) == CNT_LAST);

  // R7
  addr_step_chk: assert property (@(posedge mclk) disable iff (!mrst_n)
    !$stable(mem_addr) |-> (mem_addr == $past(mem_addr) + BLK_STEP || mem_addr == '0));

  // R8
  addr_wrap_chk: assert property (@(posedge mclk) disable iff (!mrst_n)
    ($past(mem_addr) == LAST_BLK && !$stable(mem_addr)) |-> mem_addr == '0);

  // R9
  pend_cap_chk: assert property (@(posedge mclk) disable iff (!mrst_n)
    pend != 2'd3);

  // R2
  fill_hold_chk: assert property (@(posedge mclk) disable iff (!mrst_n)
    fill_done |=> fill_done);
endmodule

// File: tb/burst_refill_ctrl_bench.sv
module burst_refill_ctrl_bench;
  localparam int MCLK_PERIOD = 10;
  localparam int PCLK_PERIOD = 25;
  localparam int FRAME = 768;
  localparam int AW = $clog2(FRAME);
  localparam int RD_VEC [8][2] = '{'{0,0}, '{1,1}, '{50,50}, '{126,126},
                                   '{128,128}, '{200,200}, '{254,254}, '{64,64}};

  logic mclk = 0, pclk = 0, mrst_n = 0, prst_n = 0;
  logic mem_begun = 0, mem_dvalid = 0, rd_en = 0;
  logic [15:0] mem_data = '0;
  logic [7:0]  rd_addr = '0;
  logic mem_req, mem_burst, fill_done;
  logic [AW-1:0] mem_addr;
  logic [15:0] rd_data;

  int total = 0, bad = 0, nreq = 0, ndone = 0, hs_bad = 0;
  int req_log [16];

  always #(MCLK_PERIOD/2) mclk = ~mclk;
  always #(PCLK_PERIOD/2.0) pclk = ~pclk;

  burst_refill_ctrl #(.FRAME_WORDS(FRAME)) u_burst_refill_ctrl (
    .mclk(mclk), .mrst_n(mrst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_begun(mem_begun), .mem_dvalid(mem_dvalid), .mem_data(mem_data),
    .mem_burst(mem_burst), .fill_done(fill_done), .pclk(pclk), .prst_n(prst_n),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  function automatic logic [15:0] w(int a);
    return 16'(a * 7 + 32'h1234);
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic rd(int a, output int d);
    @(negedge pclk); rd_en = 1; rd_addr = 8'(a);
    @(negedge pclk); rd_en = 0; d = int'(rd_data);
  endtask

  task automatic wait_done(int n);
    int t = 0;
    while (ndone < n && t < 5000) begin @(negedge mclk); t++; end
    if (ndone < n) chk("watchdog burst wait", ndone, n);
    repeat (6) @(negedge mclk);
  endtask

  // memory model
  initial begin
    int base;
    forever begin
      @(negedge mclk);
      if (mrst_n && mem_req) begin
        base = int'(mem_addr);
        if (nreq < 16) req_log[nreq] = base;
        nreq++;
        for (int i = 0; i < 2; i++) begin @(negedge mclk); if (!mem_req) hs_bad++; end
        mem_begun = 1; @(negedge mclk); mem_begun = 0;
        @(negedge mclk); mem_dvalid = 1;
        if (mem_burst) hs_bad++;
        for (int k = 0; k < 128; k++) begin
          @(negedge mclk);
          mem_dvalid = 0;
          mem_data = w(base + k);
          if (!mem_burst) hs_bad++;
        end
        @(negedge mclk);
        if (mem_burst) hs_bad++;
        ndone++;
      end
    end
  end

  initial begin
    #(200000 * MCLK_PERIOD);
    chk("watchdog global", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d;
    repeat (3) @(negedge mclk);
    // R1 reset state
    chk("R1 mem_req", int'(mem_req), 0);
    chk("R1 mem_burst", int'(mem_burst), 0);
    chk("R1 fill_done", int'(fill_done), 0);
    chk("R1 mem_addr", int'(mem_addr), 0);
    mrst_n = 1; prst_n = 1;

    wait_done(2);
    // R2 start-up fill
    chk("R2 fill_done", int'(fill_done), 1);
    chk("R2 first burst addr", req_log[0], 0);
    chk("R2 R7 second burst addr", req_log[1], 128);

    // R4 table walk of the loaded buffer
    foreach (RD_VEC[i]) begin
      rd(RD_VEC[i][0], d);
      chk("R4 buffer word", d, int'(w(RD_VEC[i][1])));
    end
    repeat (60) @(negedge mclk);
    // R5 non-trigger reads start nothing
    chk("R5 no request from plain reads", nreq, 2);

    // R5 lower half refill
    rd(127, d);
    wait_done(3);
    chk("R5 R7 lower refill addr", req_log[2], 256);
    rd(5, d);   chk("R4 lower half refreshed", d, int'(w(261)));
    rd(130, d); chk("R5 upper half untouched", d, int'(w(130)));

    // R5 upper half refill
    rd(255, d);
    wait_done(4);
    chk("R5 R7 upper refill addr", req_log[3], 384);
    rd(200, d); chk("R4 upper half refreshed", d, int'(w(456)));
    repeat (400) @(negedge mclk);
    // R6 one burst per trigger
    chk("R6 request count", nreq, 4);

    // R9 back-to-back triggers
    rd(127, d);
    rd(255, d);
    wait_done(6);
    chk("R9 held trigger count", nreq, 6);
    chk("R9 first addr", req_log[4], 512);
    chk("R9 second addr", req_log[5], 640);
    rd(10, d);  chk("R9 lower data", d, int'(w(522)));
    rd(129, d); chk("R9 upper data", d, int'(w(641)));

    // R8 wrap to frame start
    rd(127, d);
    wait_done(7);
    chk("R8 wrap addr", req_log[6], 0);
    rd(3, d); chk("R8 wrapped data", d, int'(w(3)));

    // R3 handshake observed by the model
    chk("R3 handshake errors", hs_bad, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule